// File: doc/BRIEF.md
# SPI Save-Memory Command Responder

This block sits on the device side of a byte-wide serial link and behaves like the nonvolatile save chip of a plug-in cartridge. The host shifts one byte at a time and tags each byte with a hold flag that says whether chip select stays asserted after it. The block returns one byte per exchange. A parameter picks one of three personalities: a 512-byte small EEPROM, a larger EEPROM, or a serial flash. A second parameter gives the size of the backing array.

The block decodes the first byte of a held sequence as an opcode. It then gathers one, two or three address bytes, most significant first, and walks the array with an address that increments after each data byte and wraps at the array size. A status byte carries a write-enable flag in bit 1. Flash parts also accept two erase opcodes. An internal sweep engine performs the erase, zeroing one location per clock cycle. The same engine fills the whole array with 0xFF after reset. While the sweep runs, the busy output is high and every incoming byte is dropped.

Top module: `spi_save_responder`

## Requirements
- R1: After reset, byte_out is 0x00 and busy is high for exactly MEM_BYTES cycles. After that, every array location reads back 0xFF.
- R2: A byte with hold_in high, arriving while no transfer is open, becomes the current opcode. It opens a transfer and clears the byte counter, the address and byte_out to 0x00. Nothing else happens on that byte.
- R3: The address phase lasts 1 byte for the small EEPROM, 2 bytes for the larger EEPROM and 3 bytes for flash. Bytes shift in most significant first, and byte_out is 0x00 after each address byte.
- R4: Opcode 0x03 returns the byte at the current address and opcode 0x02 stores the incoming byte there. After each data byte the address advances by one and wraps modulo MEM_BYTES.
- R5: On the small EEPROM, opcodes 0x0A (write) and 0x0B (read) add 0x100 to the address, and the sum wraps at 9 bits.
- R6: Opcode 0x06 sets status bit 1 and opcode 0x04 clears it. Both return 0x00. Opcode 0x05 returns the status byte.
- R7: Opcode 0x9F returns 0xFF and opcode 0x08 returns 0xAA. Under opcode 0x00, the next byte replaces the opcode and byte_out is left unchanged.
- R8: On flash, opcode 0x0A stores the incoming byte and opcode 0x02 stores 0x00, whatever byte arrives.
- R9: On flash, opcode 0xDB zeroes 256 bytes and opcode 0xD8 zeroes 65536 bytes, starting at the collected address. The erase starts on the last address byte. The length is clamped to MEM_BYTES, and busy stays high for that many cycles.
- R10: A byte offered while busy is high changes no state, and byte_out stays unchanged.
- R11: An unrecognised opcode leaves byte_out, the status and the array unchanged.
- R12: A byte with hold_in low, arriving while no transfer is open, is executed at once as a one-byte command. A byte with hold_in low inside an open transfer is handled under the open opcode and then closes the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | One-cycle strobe: a byte is offered |
| byte_in | input | 8 | Byte shifted in by the host |
| hold_in | input | 1 | High when chip select stays asserted after this byte |
| byte_out | output | 8 | Byte presented to the host for the next exchange |
| busy | output | 1 | High while the fill or erase sweep runs |

## Verification
The bench builds three instances side by side. The first is the default flash personality with a 4096-byte array. The second is the small EEPROM at 512 bytes. The third is the larger EEPROM personality at 4096 bytes. The 512-byte instance reaches the upper-half opcodes and the 9-bit wrap, and the two-byte EEPROM reaches the modulo wrap from 0xFFF to 0x000. With a flash array smaller than 64 KB, the big erase is clamped, so its full sweep length and its wrap over the whole array can be measured in a few thousand cycles.

// File: rtl/spi_save_pkg.sv
package spi_save_pkg;

    typedef enum logic [1:0] {
        PERS_TINY   = 2'd0,
        PERS_EEPROM = 2'd1,
        PERS_FLASH  = 2'd2
    } persona_e;

    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_READ  = 3'd1,
        ACC_WRITE = 3'd2,
        ACC_ERASE = 3'd3,
        ACC_IDENT = 3'd4
    } acc_kind_e;

    localparam int unsigned CNT_W = 17;

    typedef struct packed {
        acc_kind_e          kind;
        logic               upper;
        logic               zero_fill;
        logic [CNT_W-1:0]   erase_len;
    } acc_t;

    // control opcodes common to every personality
    localparam logic [7:0] OP_PREFIX = 8'h00;
    localparam logic [7:0] OP_WRDIS  = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_PING   = 8'h08;
    // memory opcodes
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRALT  = 8'h0A;
    localparam logic [7:0] OP_RDALT  = 8'h0B;
    localparam logic [7:0] OP_IDENT  = 8'h9F;
    localparam logic [7:0] OP_ERBIG  = 8'hD8;
    localparam logic [7:0] OP_ERPAGE = 8'hDB;

    localparam logic [7:0] PING_REPLY  = 8'hAA;
    localparam logic [7:0] IDENT_REPLY = 8'hFF;
    localparam logic [7:0] BLANK_BYTE  = 8'hFF;
    localparam int unsigned WE_BIT     = 1;

    localparam logic [CNT_W-1:0] ERASE_BIG_LEN  = 17'd65536;
    localparam logic [CNT_W-1:0] ERASE_PAGE_LEN = 17'd256;

    function automatic logic [1:0] addr_bytes(input persona_e p);
        case (p)
            PERS_TINY:   return 2'd1;
            PERS_EEPROM: return 2'd2;
            default:     return 2'd3;
        endcase
    endfunction

    function automatic acc_t classify(input persona_e p, input logic [7:0] op);
        acc_t a;
        a = '{kind: ACC_NONE, upper: 1'b0, zero_fill: 1'b0, erase_len: '0};
        if (op == OP_IDENT) begin
            a.kind = ACC_IDENT;
        end else if (op == OP_READ) begin
            a.kind = ACC_READ;
        end else begin
            case (p)
                PERS_TINY: begin
                    if (op == OP_WRITE) begin
                        a.kind = ACC_WRITE;
                    end else if (op == OP_WRALT) begin
                        a.kind  = ACC_WRITE;
                        a.upper = 1'b1;
                    end else if (op == OP_RDALT) begin
                        a.kind  = ACC_READ;
                        a.upper = 1'b1;
                    end
                end
                PERS_EEPROM: begin
                    if (op == OP_WRITE) a.kind = ACC_WRITE;
                end
                default: begin
                    if (op == OP_WRALT) begin
                        a.kind = ACC_WRITE;
                    end else if (op == OP_WRITE) begin
                        a.kind      = ACC_WRITE;
                        a.zero_fill = 1'b1;
                    end else if (op == OP_ERBIG) begin
                        a.kind      = ACC_ERASE;
                        a.erase_len = ERASE_BIG_LEN;
                    end else if (op == OP_ERPAGE) begin
                        a.kind      = ACC_ERASE;
                        a.erase_len = ERASE_PAGE_LEN;
                    end
                end
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/save_mem_array.sv
module save_mem_array #(
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/save_sweep.sv
module save_sweep
    import spi_save_pkg::*;
#(
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [AW-1:0]    base,
    input  logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [7:0]       wr_data
);
    localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);

    logic             busy_q;
    logic [AW-1:0]    ptr_q;
    logic [CNT_W-1:0] rem_q;
    logic [7:0]       fill_q;
    logic [CNT_W-1:0] span;

    // a sweep longer than the array only revisits cleared cells
    assign span = (count > DEPTH_CNT) ? DEPTH_CNT : count;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b1;
            ptr_q  <= '0;
            rem_q  <= DEPTH_CNT;
            fill_q <= BLANK_BYTE;
        end else if (busy_q) begin
            ptr_q <= ptr_q + 1'b1;
            rem_q <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1)) busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            ptr_q  <= base;
            rem_q  <= span;
            fill_q <= 8'h00;
        end
    end

    assign busy    = busy_q;
    assign wr_en   = busy_q;
    assign wr_addr = ptr_q;
    assign wr_data = fill_q;

    // R9
    sweep_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

    // R9
    sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && rem_q != CNT_W'(1)) |=> (busy_q && ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/save_cmd_engine.sv
module save_cmd_engine
    import spi_save_pkg::*;
#(
    parameter persona_e      PERSONA = PERS_FLASH,
    parameter int unsigned   DEPTH   = 4096,
    localparam int unsigned  AW      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_hold,
    input  logic             busy_i,
    input  logic [7:0]       rd_data,
    output logic [AW-1:0]    mem_addr,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             sw_start,
    output logic [AW-1:0]    sw_base,
    output logic [CNT_W-1:0] sw_len,
    output logic [7:0]       out_byte
);
    localparam logic [1:0]    NADDR     = addr_bytes(PERSONA);
    localparam logic [AW-1:0] UPPER_OFS = AW'(256);

    logic          holding_q, holding_n;
    logic [7:0]    cmd_q, cmd_n;
    logic [1:0]    pos_q, pos_n;
    logic [AW-1:0] addr_q, addr_n;
    logic [7:0]    data_q, data_n;
    logic [7:0]    status_q, status_n;

    logic          accept;
    logic [7:0]    cmd_eff;
    acc_t          acc;

    assign accept  = in_valid && !busy_i;
    assign cmd_eff = holding_q ? cmd_q : in_byte;
    assign acc     = classify(PERSONA, cmd_eff);
    assign mem_addr = acc.upper ? (addr_q + UPPER_OFS) : addr_q;
    assign wr_data  = acc.zero_fill ? 8'h00 : in_byte;
    assign sw_len   = acc.erase_len;
    assign sw_base  = addr_n;

    always_comb begin
        holding_n = holding_q;
        cmd_n     = cmd_q;
        pos_n     = pos_q;
        addr_n    = addr_q;
        data_n    = data_q;
        status_n  = status_q;
        wr_en     = 1'b0;
        sw_start  = 1'b0;
        if (accept) begin
            if (in_hold && !holding_q) begin
                cmd_n     = in_byte;
                holding_n = 1'b1;
                pos_n     = '0;
                addr_n    = '0;
                data_n    = 8'h00;
            end else begin
                if (!in_hold) begin
                    holding_n = 1'b0;
                    cmd_n     = cmd_eff;
                end
                case (cmd_eff)
                    OP_PREFIX: cmd_n = in_byte;
                    OP_PING:   data_n = PING_REPLY;
                    OP_WRDIS: begin
                        status_n[WE_BIT] = 1'b0;
                        data_n = 8'h00;
                    end
                    OP_RDSR:   data_n = status_q;
                    OP_WREN: begin
                        status_n[WE_BIT] = 1'b1;
                        data_n = 8'h00;
                    end
                    default: begin
                        if (acc.kind != ACC_NONE) begin
                            pos_n = (pos_q == 2'd3) ? pos_q : pos_q + 2'd1;
                        end
                        if (acc.kind == ACC_IDENT) begin
                            data_n = IDENT_REPLY;
                        end else if (acc.kind != ACC_NONE) begin
                            if (pos_q < NADDR) begin
                                if (PERSONA == PERS_TINY) addr_n = AW'(in_byte);
                                else                      addr_n = AW'({addr_q, in_byte});
                                data_n = 8'h00;
                                if (acc.kind == ACC_ERASE && pos_q == NADDR - 2'd1) begin
                                    sw_start = 1'b1;
                                end
                            end else if (acc.kind == ACC_READ) begin
                                data_n = rd_data;
                                addr_n = addr_q + 1'b1;
                            end else if (acc.kind == ACC_WRITE) begin
                                wr_en  = 1'b1;
                                addr_n = addr_q + 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            holding_q <= 1'b0;
            cmd_q     <= 8'h00;
            pos_q     <= '0;
            addr_q    <= '0;
            data_q    <= 8'h00;
            status_q  <= 8'h00;
        end else begin
            holding_q <= holding_n;
            cmd_q     <= cmd_n;
            pos_q     <= pos_n;
            addr_q    <= addr_n;
            data_q    <= data_n;
            status_q  <= status_n;
        end
    end

    assign out_byte = data_q;

    // R2
    latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy_i && in_hold && !holding_q) |=> (out_byte == 8'h00 && holding_q));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && busy_i) |=> ($stable(out_byte) && $stable(status_q) && $stable(addr_q)));

    // R6
    we_set_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy_i && !in_hold && !holding_q && in_byte == OP_WREN) |=> status_q[WE_BIT]);

    // R10
    no_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> (!wr_en && !sw_start));
endmodule

// File: rtl/spi_save_responder.sv
module spi_save_responder
    import spi_save_pkg::*;
#(
    parameter persona_e    PERSONA   = PERS_FLASH,
    parameter int unsigned MEM_BYTES = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    input  logic       hold_in,
    output logic [7:0] byte_out,
    output logic       busy
);
    localparam int unsigned AW = $clog2(MEM_BYTES);

    logic [AW-1:0]    eng_addr;
    logic             eng_we;
    logic [7:0]       eng_wdata;
    logic             sw_start;
    logic [AW-1:0]    sw_base;
    logic [CNT_W-1:0] sw_len;
    logic             sw_busy;
    logic             sw_we;
    logic [AW-1:0]    sw_addr;
    logic [7:0]       sw_wdata;
    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [7:0]       mem_wdata;
    logic [7:0]       mem_rdata;

    save_cmd_engine #(.PERSONA(PERSONA), .DEPTH(MEM_BYTES)) engine_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (byte_valid),
        .in_byte  (byte_in),
        .in_hold  (hold_in),
        .busy_i   (sw_busy),
        .rd_data  (mem_rdata),
        .mem_addr (eng_addr),
        .wr_en    (eng_we),
        .wr_data  (eng_wdata),
        .sw_start (sw_start),
        .sw_base  (sw_base),
        .sw_len   (sw_len),
        .out_byte (byte_out)
    );

    save_sweep #(.DEPTH(MEM_BYTES)) sweep_i (
        .clk     (clk),
        .rst     (rst),
        .start   (sw_start),
        .base    (sw_base),
        .count   (sw_len),
        .busy    (sw_busy),
        .wr_en   (sw_we),
        .wr_addr (sw_addr),
        .wr_data (sw_wdata)
    );

    assign mem_we    = sw_we | eng_we;
    assign mem_waddr = sw_we ? sw_addr  : eng_addr;
    assign mem_wdata = sw_we ? sw_wdata : eng_wdata;

    save_mem_array #(.DEPTH(MEM_BYTES)) mem_i (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (mem_waddr),
        .wr_data (mem_wdata),
        .rd_addr (eng_addr),
        .rd_data (mem_rdata)
    );

    assign busy = sw_busy;

    // R10
    single_writer_chk: assert property (@(posedge clk) disable iff (rst)
        !(sw_we && eng_we));
endmodule

// File: tb/spi_save_responder_tb.sv
module spi_save_responder_tb_top;
    import spi_save_pkg::*;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 77;
    localparam logic [1:0] SF = 2'd0, ST = 2'd1, SE = 2'd2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] byte_in = 8'h00;
    logic hold_in = 1'b0;
    logic vf = 1'b0, vt = 1'b0, ve = 1'b0;
    logic [7:0] out_f, out_t, out_e;
    logic busy_f, busy_t, busy_e;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_save_responder #(.PERSONA(PERS_FLASH), .MEM_BYTES(4096)) dut_i (
        .clk(clk), .rst(rst), .byte_valid(vf), .byte_in(byte_in), .hold_in(hold_in),
        .byte_out(out_f), .busy(busy_f));
    spi_save_responder #(.PERSONA(PERS_TINY), .MEM_BYTES(512)) tiny_i (
        .clk(clk), .rst(rst), .byte_valid(vt), .byte_in(byte_in), .hold_in(hold_in),
        .byte_out(out_t), .busy(busy_t));
    spi_save_responder #(.PERSONA(PERS_EEPROM), .MEM_BYTES(4096)) eep_i (
        .clk(clk), .rst(rst), .byte_valid(ve), .byte_in(byte_in), .hold_in(hold_in),
        .byte_out(out_e), .busy(busy_e));

    // row: {req, target, hold, compare, byte, expected}
    localparam logic [23:0] VEC [NV] = '{
        // R2 / R3 / R1 : fresh read on the two-byte EEPROM
        {4'd2, SE,1'b1,1'b1,8'h03,8'h00}, {4'd3, SE,1'b1,1'b1,8'h00,8'h00},
        {4'd3, SE,1'b1,1'b1,8'h40,8'h00}, {4'd1, SE,1'b0,1'b1,8'h00,8'hFF},
        // R12 single-byte command, R6 status
        {4'd12,SE,1'b0,1'b1,8'h06,8'h00}, {4'd2, SE,1'b1,1'b1,8'h05,8'h00},
        {4'd6, SE,1'b0,1'b1,8'h00,8'h02}, {4'd6, SE,1'b0,1'b1,8'h04,8'h00},
        {4'd6, SE,1'b1,1'b0,8'h05,8'h00}, {4'd6, SE,1'b0,1'b1,8'h00,8'h00},
        // R4 write then read back
        {4'd4, SE,1'b1,1'b0,8'h02,8'h00}, {4'd4, SE,1'b1,1'b0,8'h01,8'h00},
        {4'd4, SE,1'b1,1'b0,8'h23,8'h00}, {4'd4, SE,1'b1,1'b0,8'h5A,8'h00},
        {4'd4, SE,1'b0,1'b0,8'hA5,8'h00}, {4'd4, SE,1'b1,1'b0,8'h03,8'h00},
        {4'd4, SE,1'b1,1'b0,8'h01,8'h00}, {4'd4, SE,1'b1,1'b0,8'h23,8'h00},
        {4'd4, SE,1'b1,1'b1,8'h00,8'h5A}, {4'd4, SE,1'b0,1'b1,8'h00,8'hA5},
        // R4 wrap 0xFFF -> 0x000
        {4'd4, SE,1'b1,1'b0,8'h02,8'h00}, {4'd4, SE,1'b1,1'b0,8'h0F,8'h00},
        {4'd4, SE,1'b1,1'b0,8'hFF,8'h00}, {4'd4, SE,1'b1,1'b0,8'h11,8'h00},
        {4'd4, SE,1'b0,1'b0,8'h22,8'h00}, {4'd4, SE,1'b1,1'b0,8'h03,8'h00},
        {4'd4, SE,1'b1,1'b0,8'h0F,8'h00}, {4'd4, SE,1'b1,1'b0,8'hFF,8'h00},
        {4'd4, SE,1'b1,1'b1,8'h00,8'h11}, {4'd4, SE,1'b0,1'b1,8'h00,8'h22},
        // R3 one address byte, R5 upper half, on the small EEPROM
        {4'd3, ST,1'b1,1'b0,8'h02,8'h00}, {4'd3, ST,1'b1,1'b0,8'h10,8'h00},
        {4'd3, ST,1'b0,1'b0,8'h33,8'h00}, {4'd5, ST,1'b1,1'b0,8'h0A,8'h00},
        {4'd5, ST,1'b1,1'b0,8'h10,8'h00}, {4'd5, ST,1'b0,1'b0,8'h44,8'h00},
        {4'd3, ST,1'b1,1'b0,8'h03,8'h00}, {4'd3, ST,1'b1,1'b1,8'h10,8'h00},
        {4'd3, ST,1'b0,1'b1,8'h00,8'h33}, {4'd5, ST,1'b1,1'b0,8'h0B,8'h00},
        {4'd5, ST,1'b1,1'b0,8'h10,8'h00}, {4'd5, ST,1'b0,1'b1,8'h00,8'h44},
        {4'd5, ST,1'b1,1'b0,8'h02,8'h00}, {4'd5, ST,1'b1,1'b0,8'h00,8'h00},
        {4'd5, ST,1'b0,1'b0,8'h77,8'h00}, {4'd5, ST,1'b1,1'b0,8'h0B,8'h00},
        {4'd5, ST,1'b1,1'b0,8'hFF,8'h00}, {4'd5, ST,1'b1,1'b1,8'h00,8'hFF},
        {4'd5, ST,1'b0,1'b1,8'h00,8'h77},
        // R7 fixed replies and prefix on flash
        {4'd7, SF,1'b1,1'b1,8'h9F,8'h00}, {4'd7, SF,1'b0,1'b1,8'h00,8'hFF},
        {4'd7, SF,1'b1,1'b0,8'h08,8'h00}, {4'd7, SF,1'b0,1'b1,8'h00,8'hAA},
        {4'd6, SF,1'b0,1'b0,8'h06,8'h00}, {4'd7, SF,1'b1,1'b1,8'h00,8'h00},
        {4'd7, SF,1'b1,1'b1,8'h05,8'h00}, {4'd7, SF,1'b0,1'b1,8'h00,8'h02},
        // R8 flash data write and zero write
        {4'd8, SF,1'b1,1'b0,8'h0A,8'h00}, {4'd8, SF,1'b1,1'b0,8'h00,8'h00},
        {4'd8, SF,1'b1,1'b0,8'h01,8'h00}, {4'd8, SF,1'b1,1'b0,8'h00,8'h00},
        {4'd8, SF,1'b1,1'b0,8'h12,8'h00}, {4'd8, SF,1'b0,1'b0,8'h34,8'h00},
        {4'd8, SF,1'b1,1'b0,8'h02,8'h00}, {4'd8, SF,1'b1,1'b0,8'h00,8'h00},
        {4'd8, SF,1'b1,1'b0,8'h01,8'h00}, {4'd8, SF,1'b1,1'b0,8'h00,8'h00},
        {4'd8, SF,1'b0,1'b0,8'h99,8'h00}, {4'd8, SF,1'b1,1'b0,8'h03,8'h00},
        {4'd8, SF,1'b1,1'b1,8'h00,8'h00}, {4'd8, SF,1'b1,1'b1,8'h01,8'h00},
        {4'd8, SF,1'b1,1'b1,8'h00,8'h00}, {4'd8, SF,1'b1,1'b1,8'h00,8'h00},
        {4'd8, SF,1'b0,1'b1,8'h00,8'h34},
        // R11 unknown opcode
        {4'd11,SF,1'b0,1'b1,8'h77,8'h34}, {4'd11,SF,1'b1,1'b0,8'h05,8'h00},
        {4'd11,SF,1'b0,1'b1,8'h00,8'h02}
    };

    function automatic logic [7:0] pick(input logic [1:0] sel);
        case (sel)
            SF:      return out_f;
            ST:      return out_t;
            default: return out_e;
        endcase
    endfunction

    // called at a falling edge; one rising edge passes
    task automatic send(input logic [1:0] sel, input logic [7:0] b, input logic h,
                        output logic [7:0] got);
        byte_in = b;
        hold_in = h;
        vf = (sel == SF);
        vt = (sel == ST);
        ve = (sel == SE);
        @(negedge clk);
        vf = 1'b0; vt = 1'b0; ve = 1'b0;
        got = pick(sel);
    endtask

    task automatic check(input int req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] got;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(1, "byte_out in reset", out_f, 8'h00);
        check(1, "busy in reset", busy_f, 1);
        rst = 1'b0;
        n = 0;
        while (busy_f) begin
            @(negedge clk);
            n++;
        end
        check(1, "fill cycles", n, 4096);
        while (busy_t || busy_e) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] row;
            row = VEC[i];
            send(row[19:18], row[15:8], row[17], got);
            if (row[16]) check(int'(row[23:20]), $sformatf("vector %0d", i), got, row[7:0]);
        end

        // R9 page erase: 0x2FF=AB, 0x300=CD, erase 0x200..0x2FF
        send(SF, OP_WRALT, 1'b1, got); send(SF, 8'h00, 1'b1, got);
        send(SF, 8'h02, 1'b1, got);    send(SF, 8'hFF, 1'b1, got);
        send(SF, 8'hAB, 1'b1, got);    send(SF, 8'hCD, 1'b0, got);
        send(SF, OP_ERPAGE, 1'b1, got); send(SF, 8'h00, 1'b1, got);
        send(SF, 8'h02, 1'b1, got);    send(SF, 8'h00, 1'b0, got);
        check(9, "busy after page erase start", busy_f, 1);
        n = 0;
        while (busy_f) begin
            @(negedge clk);
            n++;
        end
        check(9, "page erase cycles", n, 256);
        send(SF, OP_READ, 1'b1, got); send(SF, 8'h00, 1'b1, got);
        send(SF, 8'h02, 1'b1, got);   send(SF, 8'hFF, 1'b1, got);
        send(SF, 8'h00, 1'b1, got);
        check(9, "erased 0x2FF", got, 8'h00);
        send(SF, 8'h00, 1'b0, got);
        check(9, "0x300 kept", got, 8'hCD);

        // R9 big erase clamped to the array, R10 byte dropped while busy
        send(SF, OP_ERBIG, 1'b1, got); send(SF, 8'h00, 1'b1, got);
        send(SF, 8'h00, 1'b1, got);    send(SF, 8'h00, 1'b0, got);
        check(9, "busy after big erase start", busy_f, 1);
        send(SF, OP_WRDIS, 1'b0, got);
        check(10, "byte_out while busy", got, 8'h00);
        n = 1;
        while (busy_f) begin
            @(negedge clk);
            n++;
        end
        check(9, "big erase cycles", n, 4096);
        send(SF, OP_RDSR, 1'b1, got); send(SF, 8'h00, 1'b0, got);
        check(10, "status after dropped byte", got, 8'h02);
        send(SF, OP_READ, 1'b1, got); send(SF, 8'h00, 1'b1, got);
        send(SF, 8'h03, 1'b1, got);   send(SF, 8'h00, 1'b1, got);
        send(SF, 8'h00, 1'b0, got);
        check(9, "0x300 erased by big erase", got, 8'h00);

        finish_run();
    end
endmodule